// File: doc/BRIEF.md
# SIMD Control Register Load Checker

This block carries out a load of the 32-bit SIMD control/status register from a memory word. Each request supplies the word read from memory, its linear address, the processor mode, the current privilege level and six system control bits. The block either commits the word to the register or refuses the load and reports one fault code. When several fault conditions hold together, only the one with the highest priority is reported.

A request is a one-cycle `req_valid` pulse with all inputs valid in that cycle. One clock later `rsp_valid` pulses for one cycle. With it comes either `rsp_commit=1`, in which case `csr_value` holds the new word from the same edge, or `rsp_commit=0` with a nonzero fault code. A refused load leaves the register untouched. Page translation is outside this block. Segment checking is limited to a fixed 16-bit offset bound in the two non-protected modes.

Top module: `simd_ctl_loader`

## Requirements
- R1: `rsp_valid` is high in the cycle after each cycle in which `req_valid` is high, and low in the cycle after each cycle in which `req_valid` is low.
- R2: During and after reset, `csr_value` is 0x00001F80 and `rsp_valid` is 0.
- R3: If `ctl_emul`=1, or `ctl_os_simd`=0, or `feat_simd`=0, the response carries fault code 1 (invalid opcode). This fault outranks every other fault.
- R4: If `ctl_task_sw`=1 and R3 does not apply, the response carries fault code 2 (device not available).
- R5: Mode encoding is 0 = real, 1 = virtual-8086, 2 or 3 = protected. In real or virtual-8086 mode, if `req_addr`+3 > 0xFFFF, the response carries fault code 3 (general protection, vector 13). This check is lower than R4 and does not apply in protected mode.
- R6: Fault code 4 (alignment check) is raised when all of these hold: `ctl_align_mask`=1, `flag_align`=1, the effective privilege is 3, and `req_addr[1:0]`≠0. The effective privilege is always 3 in virtual-8086 mode and is `req_cpl` in protected mode. Real mode never raises this fault. It ranks below R5.
- R7: A loaded word with any 1 in bits 31..16 or bit 6 gives fault code 5 (general protection, reserved bits). This is the lowest-priority fault.
- R8: When no fault applies, the response has `rsp_commit`=1 and `rsp_fault`=0, and `csr_value` equals the loaded word from that same cycle.
- R9: A faulting response has `rsp_commit`=0 and leaves `csr_value` unchanged. `rsp_errcode` is 0 on every response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Load request strobe |
| req_data | input | 32 | Word loaded from memory |
| req_addr | input | 32 | Linear address of operand low byte |
| req_mode | input | 2 | 0 real, 1 virtual-8086, 2/3 protected |
| req_cpl | input | 2 | Current privilege level |
| ctl_emul | input | 1 | Emulation control bit |
| ctl_task_sw | input | 1 | Task-switched bit |
| ctl_align_mask | input | 1 | Alignment-mask control bit |
| flag_align | input | 1 | Flags alignment-check bit |
| ctl_os_simd | input | 1 | OS SIMD-support enable |
| feat_simd | input | 1 | SIMD feature present |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_commit | output | 1 | Load accepted |
| rsp_fault | output | 4 | Fault code (0 none) |
| rsp_errcode | output | 16 | Error code pushed with the fault |
| csr_value | output | 32 | Current register contents |

## Verification
The case that is hardest to reach is an alignment fault whose only competitor is a reserved-bit violation. Every gating bit must be clear, the address must lie inside the bound (or the mode must be protected), and all four alignment conditions must hold together. Uniform random inputs almost never produce this combination. The stimulus therefore sets each blocking condition only with low probability, sets the alignment enables with high probability, and draws addresses near 0xFFFC with a quarter of draws. Directed loads then stack alignment and reserved-bit faults in every mode.

// File: rtl/simd_ld_pkg.sv
package simd_ld_pkg;
    localparam logic [1:0] MODE_REAL = 2'd0;
    localparam logic [1:0] MODE_V86  = 2'd1;

    localparam int FAULT_W = 4;
    localparam logic [FAULT_W-1:0] FLT_NONE  = 4'd0;
    localparam logic [FAULT_W-1:0] FLT_UD    = 4'd1;
    localparam logic [FAULT_W-1:0] FLT_NM    = 4'd2;
    localparam logic [FAULT_W-1:0] FLT_SEG   = 4'd3;
    localparam logic [FAULT_W-1:0] FLT_ALIGN = 4'd4;
    localparam logic [FAULT_W-1:0] FLT_RSVD  = 4'd5;

    typedef struct packed {
        logic ud;
        logic nm;
        logic seg;
        logic align;
        logic rsvd;
    } fault_cond_t;
endpackage

// File: rtl/simd_ld_addr_chk.sv
module simd_ld_addr_chk #(
    parameter int ADDR_W = 32,
    parameter int OPND_BYTES = 4,
    parameter logic [ADDR_W-1:0] SEG_LIMIT = 'hFFFF
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        mode,
    input  logic [1:0]        cpl,
    input  logic              align_mask,
    input  logic              align_flag,
    output logic              seg_fault,
    output logic              align_fault
);
    import simd_ld_pkg::*;

    localparam int ALIGN_BITS = $clog2(OPND_BYTES);
    localparam logic [ADDR_W:0] LAST_OFS = (ADDR_W+1)'(OPND_BYTES - 1);

    logic [ADDR_W:0] end_ofs;
    logic            bounded_mode;
    logic            eff_user;
    logic            misaligned;

    always_comb begin
        bounded_mode = (mode == MODE_REAL) || (mode == MODE_V86);
        end_ofs      = {1'b0, addr} + LAST_OFS;
        seg_fault    = bounded_mode && (end_ofs > {1'b0, SEG_LIMIT});
        eff_user     = (mode == MODE_V86) || ((mode != MODE_REAL) && (cpl == 2'd3));
        align_fault  = align_mask && align_flag && eff_user && misaligned;
    end

    generate
        if (ALIGN_BITS > 0) begin : g_align
            assign misaligned = |addr[ALIGN_BITS-1:0];
        end else begin : g_noalign
            assign misaligned = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/simd_ld_fault_pri.sv
module simd_ld_fault_pri (
    input  simd_ld_pkg::fault_cond_t    cond,
    output logic [simd_ld_pkg::FAULT_W-1:0] code
);
    import simd_ld_pkg::*;

    always_comb begin
        if (cond.ud)         code = FLT_UD;
        else if (cond.nm)    code = FLT_NM;
        else if (cond.seg)   code = FLT_SEG;
        else if (cond.align) code = FLT_ALIGN;
        else if (cond.rsvd)  code = FLT_RSVD;
        else                 code = FLT_NONE;
    end
endmodule

// File: rtl/simd_ctl_loader.sv
module simd_ctl_loader #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int OPND_BYTES = 4,
    parameter logic [ADDR_W-1:0] SEG_LIMIT = 'hFFFF,
    parameter logic [DATA_W-1:0] RST_VAL   = 'h0000_1F80,
    parameter logic [DATA_W-1:0] RSVD_MASK = 'hFFFF_0040,
    parameter int ERR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [DATA_W-1:0] req_data,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_mode,
    input  logic [1:0]        req_cpl,
    input  logic              ctl_emul,
    input  logic              ctl_task_sw,
    input  logic              ctl_align_mask,
    input  logic              flag_align,
    input  logic              ctl_os_simd,
    input  logic              feat_simd,
    output logic              rsp_valid,
    output logic              rsp_commit,
    output logic [3:0]        rsp_fault,
    output logic [ERR_W-1:0]  rsp_errcode,
    output logic [DATA_W-1:0] csr_value
);
    import simd_ld_pkg::*;

    typedef struct packed {
        logic               valid;
        logic               commit;
        logic [FAULT_W-1:0] fault;
        logic [DATA_W-1:0]  csr;
    } state_t;

    localparam state_t RST_STATE = '{valid: 1'b0, commit: 1'b0,
                                     fault: FLT_NONE, csr: RST_VAL};

    state_t      st_d, st_q;
    fault_cond_t cond;
    logic        seg_f, align_f;
    logic [FAULT_W-1:0] code;

    simd_ld_addr_chk #(
        .ADDR_W(ADDR_W), .OPND_BYTES(OPND_BYTES), .SEG_LIMIT(SEG_LIMIT)
    ) u_addr (
        .addr(req_addr), .mode(req_mode), .cpl(req_cpl),
        .align_mask(ctl_align_mask), .align_flag(flag_align),
        .seg_fault(seg_f), .align_fault(align_f)
    );

    always_comb begin
        cond.ud    = ctl_emul || !ctl_os_simd || !feat_simd;
        cond.nm    = ctl_task_sw;
        cond.seg   = seg_f;
        cond.align = align_f;
        cond.rsvd  = |(req_data & RSVD_MASK);
    end

    simd_ld_fault_pri u_pri (.cond(cond), .code(code));

    always_comb begin
        st_d        = st_q;
        st_d.valid  = req_valid;
        st_d.commit = 1'b0;
        st_d.fault  = FLT_NONE;
        if (req_valid) begin
            st_d.fault  = code;
            st_d.commit = (code == FLT_NONE);
            if (code == FLT_NONE) st_d.csr = req_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RST_STATE;
        else        st_q <= st_d;
    end

    assign rsp_valid   = st_q.valid;
    assign rsp_commit  = st_q.commit;
    assign rsp_fault   = st_q.fault;
    assign rsp_errcode = '0;
    assign csr_value   = st_q.csr;

    assert_resp_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_no_spurious_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    assert_ud_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (ctl_emul || !ctl_os_simd || !feat_simd))
        |=> (rsp_fault == FLT_UD) && !rsp_commit);
    assert_nm_next_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ctl_task_sw && !ctl_emul && ctl_os_simd && feat_simd)
        |=> (rsp_fault == FLT_NM));
    assert_clean_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_commit) |-> ((csr_value & RSVD_MASK) == '0));
    assert_commit_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_commit == (rsp_fault == FLT_NONE)));
    assert_commit_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_commit) |-> (csr_value == $past(req_data)));
    assert_fault_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_commit) |-> $stable(csr_value));
endmodule

// File: tb/sim_simd_ctl_loader.sv
module sim_simd_ctl_loader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_data = '0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_mode = '0;
    logic [1:0]  req_cpl = '0;
    logic        ctl_emul = 0, ctl_task_sw = 0, ctl_align_mask = 0;
    logic        flag_align = 0, ctl_os_simd = 1, feat_simd = 1;
    logic        rsp_valid, rsp_commit;
    logic [3:0]  rsp_fault;
    logic [15:0] rsp_errcode;
    logic [31:0] csr_value;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] exp_csr = 32'h0000_1F80;

    always #5 clk = ~clk;

    simd_ctl_loader u0 (.*);

    function automatic logic [3:0] ref_fault(
        input logic [31:0] d, input logic [31:0] a, input logic [1:0] m,
        input logic [1:0] c, input logic em, input logic ts, input logic am,
        input logic ac, input logic os, input logic ft);
        logic bounded, user;
        bounded = (m == 2'd0) || (m == 2'd1);
        user = (m == 2'd1) || (m >= 2'd2 && c == 2'd3);
        if (em || !os || !ft) return 4'd1;
        if (ts) return 4'd2;
        if (bounded && ({1'b0, a} + 33'd3 > 33'h0FFFF)) return 4'd3;
        if (am && ac && user && a[1:0] != 2'b00) return 4'd4;
        if ((d & 32'hFFFF_0040) != 0) return 4'd5;
        return 4'd0;
    endfunction

    function automatic string tag_of(input logic [3:0] f);
        case (f)
            4'd1: return "R3";
            4'd2: return "R4";
            4'd3: return "R5";
            4'd4: return "R6";
            4'd5: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_load(input logic [31:0] d, input logic [31:0] a,
                           input logic [1:0] m, input logic [1:0] c,
                           input logic em, input logic ts, input logic am,
                           input logic ac, input logic os, input logic ft);
        logic [3:0] ef;
        ef = ref_fault(d, a, m, c, em, ts, am, ac, os, ft);
        @(negedge clk);
        req_valid = 1; req_data = d; req_addr = a; req_mode = m; req_cpl = c;
        ctl_emul = em; ctl_task_sw = ts; ctl_align_mask = am; flag_align = ac;
        ctl_os_simd = os; feat_simd = ft;
        @(negedge clk);
        req_valid = 0;
        if (ef == 4'd0) exp_csr = d;
        check("R1 valid", {31'd0, rsp_valid}, 32'd1);
        check(tag_of(ef), {27'd0, rsp_commit, rsp_fault}, {27'd0, ef == 4'd0, ef});
        check(ef == 4'd0 ? "R8 csr" : "R9 csr", csr_value, exp_csr);
        check("R9 errcode", {16'd0, rsp_errcode}, 32'd0);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
        $finish;
    end

    initial begin
        logic [31:0] d, a;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check("R2 csr", csr_value, 32'h0000_1F80);
        check("R2 valid", {31'd0, rsp_valid}, 32'd0);
        rst_n = 1;
        @(negedge clk);
        check("R2 idle", {31'd0, rsp_valid}, 32'd0);

        // R8 clean commit in protected mode, misaligned but checks disabled
        do_load(32'h0000_1F3F, 32'h1234_5679, 2'd2, 2'd3, 0, 0, 0, 1, 1, 1);
        @(negedge clk);
        check("R1 pulse ends", {31'd0, rsp_valid}, 32'd0);
        // R3 each gating bit, stacked with others
        do_load(32'hFFFF_FFFF, 32'h0000_FFFF, 2'd0, 2'd0, 1, 1, 1, 1, 1, 1);
        do_load(32'h0000_0000, 32'h0, 2'd2, 2'd0, 0, 1, 0, 0, 0, 1);
        do_load(32'h0000_0000, 32'h0, 2'd2, 2'd0, 0, 0, 0, 0, 1, 0);
        // R4 over segment
        do_load(32'h0000_0000, 32'h0000_FFFE, 2'd0, 2'd0, 0, 1, 0, 0, 1, 1);
        // R5 boundary: 0xFFFC ok, 0xFFFD faults, protected no bound
        do_load(32'h0000_0001, 32'h0000_FFFC, 2'd0, 2'd0, 0, 0, 0, 0, 1, 1);
        do_load(32'h0000_0002, 32'h0000_FFFD, 2'd0, 2'd0, 0, 0, 1, 1, 1, 1);
        do_load(32'h0000_0003, 32'h0001_0000, 2'd1, 2'd0, 0, 0, 1, 1, 1, 1);
        do_load(32'h0000_0004, 32'h0001_0000, 2'd2, 2'd0, 0, 0, 0, 0, 1, 1);
        // R6 alignment per mode, stacked over reserved bits
        do_load(32'h0000_0040, 32'h0000_0101, 2'd1, 2'd0, 0, 0, 1, 1, 1, 1);
        do_load(32'h0000_0040, 32'h0000_0102, 2'd0, 2'd3, 0, 0, 1, 1, 1, 1);
        do_load(32'h0000_0040, 32'h0000_0103, 2'd3, 2'd3, 0, 0, 1, 1, 1, 1);
        do_load(32'h0000_0005, 32'h0000_0103, 2'd2, 2'd2, 0, 0, 1, 1, 1, 1);
        do_load(32'h0000_0006, 32'h0000_0101, 2'd2, 2'd3, 0, 0, 1, 0, 1, 1);
        // R7 reserved bits individually
        do_load(32'h8000_0000, 32'h0, 2'd2, 2'd0, 0, 0, 0, 0, 1, 1);
        do_load(32'h0001_0000, 32'h0, 2'd2, 2'd0, 0, 0, 0, 0, 1, 1);
        do_load(32'h0000_FFBF, 32'h0, 2'd2, 2'd0, 0, 0, 0, 0, 1, 1);

        for (int i = 0; i < 600; i++) begin
            d = $urandom;
            if ($urandom_range(1, 0) == 1) d = d & 32'h0000_FFBF;
            a = $urandom;
            if ($urandom_range(3, 0) == 0) a = 32'h0000_FFF8 + $urandom_range(7, 0);
            else if ($urandom_range(1, 0) == 0) a = a & 32'h0000_FFFF;
            do_load(d, a, 2'($urandom_range(3, 0)), 2'($urandom_range(3, 0)),
                    $urandom_range(15, 0) == 0, $urandom_range(7, 0) == 0,
                    $urandom_range(3, 0) != 0, $urandom_range(3, 0) != 0,
                    $urandom_range(15, 0) != 0, $urandom_range(15, 0) != 0);
        end
        @(negedge clk);
        check("R1 final idle", {31'd0, rsp_valid}, 32'd0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule